// File: doc/BRIEF.md
# Configurable Programmable-Logic Macrocell

This block is one logic cell of a small programmable logic device. A sum-of-products term arrives on `sop_in`. The cell either stores it in a D flip-flop, uses it as the toggle control of a T flip-flop, or passes it straight through. Static configuration inputs set the following:

- the storage mode;
- which of six clock sources triggers the storage element: four global clock lines and two local control terms;
- the active edge of each global clock;
- whether the local control terms may preset or clear the flip-flop asynchronously;
- where the output enable comes from.

The cell value drives a bidirectional pin through a tri-state buffer. An active-low global tri-state input can release every pin. Two feedback signals go back to the routing:

- one taken before the buffer;
- one read from the pin itself, so the pin can serve as an input while the buffer is released.

All clock sources are sampled on one reference clock. An edge on the selected source becomes a one-cycle load enable, so the cell stays fully synchronous apart from its power-on reset and its asynchronous preset/clear. Configuration inputs are expected to stay constant while the cell runs.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst_n` is low, the stored bit is 0, and `fb_cell` reads 0 in either register mode.
- R2: With `cfg_mode`=01 (D), an active clock event loads `sop_in` into the stored bit, and `fb_cell` shows the stored bit.
- R3: With `cfg_mode`=10 (T), an active clock event inverts the stored bit when `sop_in` is 1 and keeps it when `sop_in` is 0.
- R4: With `cfg_mode`=00 or 11, `fb_cell` follows `sop_in` combinationally, with no clock event.
- R5: `cfg_clk_sel` chooses the clock source: values 0 to 3 select `gclk[0]` to `gclk[3]`, 4 selects `ct[2]`, 5 selects `ct[3]`, and 6 or 7 selects none. Edges on sources that are not selected do not change the stored bit.
- R6: A global clock `gclk[n]` is active on its falling edge when `cfg_gclk_fall[n]`=1 and on its rising edge otherwise. The control-term clocks are active on their rising edge. An edge is seen on the first reference-clock rising edge after the source changes.
- R7: With `cfg_pr_en`=1, `ct[0]` high clears the stored bit and `ct[1]` high sets it, at once and without a clock edge. When both are high, the clear wins.
- R8: With `cfg_pr_en`=0, `ct[0]` and `ct[1]` have no effect on the stored bit.
- R9: `cfg_oe_sel` picks the local output enable: 0 = never, 1 = always, 2 to 5 = `ct[2]` to `ct[5]`, 6 or 7 = never. When the buffer is enabled, the pin carries `fb_cell`; otherwise it is high impedance.
- R10: When `cfg_gts_en`=1 and `gts_n`=0, the pin is high impedance whatever the local enable is, while `fb_cell` keeps its value.
- R11: `fb_pin` carries the pin value: the driven cell value when the buffer is enabled, and the external level when it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock on which all clock sources are sampled |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| cfg_mode | input | 2 | Storage mode: 00/11 combinational, 01 D, 10 T |
| cfg_clk_sel | input | 3 | Clock source select |
| cfg_gclk_fall | input | 4 | Per global clock: 1 = falling edge active |
| cfg_pr_en | input | 1 | Enables asynchronous preset/clear from ct[1]/ct[0] |
| cfg_oe_sel | input | 3 | Output-enable source select |
| cfg_gts_en | input | 1 | Enables the global tri-state input |
| sop_in | input | 1 | Sum-of-products data input |
| gclk | input | 4 | Global clock lines |
| ct | input | 6 | Local control terms |
| gts_n | input | 1 | Global tri-state, active low |
| pin_io | inout | 1 | Bidirectional device pin |
| fb_cell | output | 1 | Feedback taken before the output buffer |
| fb_pin | output | 1 | Feedback read from the pin |

## Verification
Assertions watch the storage element on every reference cycle:

- a D-mode event loads the data;
- a T-mode event applies the toggle rule;
- a cycle with no event and no preset/clear leaves the bit unchanged;
- an active clear always forces zero;
- the bit is zero when reset is released.

Only the bench scenarios show the rest:

- that edges on unselected sources are ignored;
- that the falling-edge option works;
- that preset and clear act between clock edges and are ignored when disabled;
- that the output-enable and global tri-state choices release the pin;
- that the pin feedback follows an external driver.

// File: rtl/pld_macrocell.sv
module pld_macrocell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic [2:0] cfg_clk_sel,
  input  logic [3:0] cfg_gclk_fall,
  input  logic       cfg_pr_en,
  input  logic [2:0] cfg_oe_sel,
  input  logic       cfg_gts_en,
  input  logic       sop_in,
  input  logic [3:0] gclk,
  input  logic [5:0] ct,
  input  logic       gts_n,
  inout  wire        pin_io,
  output logic       fb_cell,
  output logic       fb_pin
);

  localparam logic [1:0] MODE_D = 2'b01;
  localparam logic [1:0] MODE_T = 2'b10;

  logic [5:0] src_now, src_prev;
  logic       q, tick, clr_a, set_a, nxt, oe_local, drive;
  logic       reg_mode;

  assign src_now = {ct[3:2], gclk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) src_prev <= '0;
    else        src_prev <= src_now;

  always_comb begin
    tick = 1'b0;
    case (cfg_clk_sel)
      3'd0, 3'd1, 3'd2, 3'd3:
        tick = cfg_gclk_fall[cfg_clk_sel[1:0]]
             ? (src_prev[cfg_clk_sel[1:0]] & ~src_now[cfg_clk_sel[1:0]])
             : (~src_prev[cfg_clk_sel[1:0]] & src_now[cfg_clk_sel[1:0]]);
      3'd4:    tick = src_now[4] & ~src_prev[4];
      3'd5:    tick = src_now[5] & ~src_prev[5];
      default: tick = 1'b0;
    endcase
  end

  assign clr_a = cfg_pr_en & ct[0];
  assign set_a = cfg_pr_en & ct[1];
  assign nxt   = (cfg_mode == MODE_T) ? (q ^ sop_in) : sop_in;

  always_ff @(posedge clk or negedge rst_n or posedge clr_a or posedge set_a)
    if (!rst_n)     q <= 1'b0;
    else if (clr_a) q <= 1'b0;
    else if (set_a) q <= 1'b1;
    else if (tick)  q <= nxt;

  assign reg_mode = (cfg_mode == MODE_D) || (cfg_mode == MODE_T);
  assign fb_cell  = reg_mode ? q : sop_in;

  always_comb begin
    case (cfg_oe_sel)
      3'd1:    oe_local = 1'b1;
      3'd2:    oe_local = ct[2];
      3'd3:    oe_local = ct[3];
      3'd4:    oe_local = ct[4];
      3'd5:    oe_local = ct[5];
      default: oe_local = 1'b0;
    endcase
  end

  assign drive  = oe_local & ~(cfg_gts_en & ~gts_n);
  assign pin_io = drive ? fb_cell : 1'bz;
  assign fb_pin = pin_io;

  assert_d_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == MODE_D && tick && !clr_a && !set_a)
      |=> (clr_a || set_a || q == $past(sop_in)));

  assert_t_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == MODE_T && tick && !clr_a && !set_a)
      |=> (clr_a || set_a || q == ($past(q) ^ $past(sop_in))));

  assert_hold_no_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr_a && !set_a) |=> (clr_a || set_a || $stable(q)));

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_a |-> (q == 1'b0));

  assert_por_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !set_a) |-> (q == 1'b0));

endmodule

// File: tb/pld_macrocell_tb.sv
`timescale 1ns/1ps
module pld_macrocell_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b01;
  logic [2:0] cfg_clk_sel = 3'd0;
  logic [3:0] cfg_gclk_fall = 4'b0;
  logic       cfg_pr_en = 1'b0;
  logic [2:0] cfg_oe_sel = 3'd0;
  logic       cfg_gts_en = 1'b0;
  logic       sop_in = 1'b0;
  logic [3:0] gclk = 4'b0;
  logic [5:0] ct = 6'b0;
  logic       gts_n = 1'b1;
  logic       ext_en = 1'b0, ext_val = 1'b0;
  wire        pin_io;
  logic       fb_cell, fb_pin;
  int         checks = 0, errors = 0;

  assign pin_io = ext_en ? ext_val : 1'bz;

  always #4 clk = ~clk;

  pld_macrocell u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
    .cfg_gclk_fall(cfg_gclk_fall), .cfg_pr_en(cfg_pr_en), .cfg_oe_sel(cfg_oe_sel),
    .cfg_gts_en(cfg_gts_en), .sop_in(sop_in), .gclk(gclk), .ct(ct), .gts_n(gts_n),
    .pin_io(pin_io), .fb_cell(fb_cell), .fb_pin(fb_pin));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic clear_bit();
    cfg_pr_en = 1'b1; ct[0] = 1'b1;
    @(negedge clk); ct[0] = 1'b0; cfg_pr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic gpulse(input int n);
    gclk[n] = 1'b1; @(negedge clk);
    gclk[n] = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    #1 chk("R1 stored bit zero during reset", fb_cell, 1'b0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R1 stored bit zero after reset", fb_cell, 1'b0);
  endtask

  task automatic t_dmode();
    cfg_mode = 2'b01; cfg_clk_sel = 3'd0;
    sop_in = 1'b1; gpulse(0);
    chk("R2 D loads 1", fb_cell, 1'b1);
    sop_in = 1'b0; @(negedge clk);
    chk("R2 D holds without event", fb_cell, 1'b1);
    gpulse(0);
    chk("R2 D loads 0", fb_cell, 1'b0);
  endtask

  task automatic t_tmode();
    cfg_mode = 2'b10; clear_bit();
    sop_in = 1'b1; gpulse(0);
    chk("R3 T toggles to 1", fb_cell, 1'b1);
    gpulse(0);
    chk("R3 T toggles to 0", fb_cell, 1'b0);
    gpulse(0);
    sop_in = 1'b0; gpulse(0);
    chk("R3 T holds with 0 input", fb_cell, 1'b1);
  endtask

  task automatic t_comb();
    cfg_mode = 2'b00; sop_in = 1'b0; #1;
    chk("R4 comb follows 0", fb_cell, 1'b0);
    sop_in = 1'b1; #1;
    chk("R4 comb follows 1", fb_cell, 1'b1);
    cfg_mode = 2'b11; sop_in = 1'b0; #1;
    chk("R4 mode 11 follows 0", fb_cell, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_clksel();
    cfg_mode = 2'b01; clear_bit();
    cfg_clk_sel = 3'd4; sop_in = 1'b1;
    gpulse(0);
    chk("R5 unselected gclk0 ignored", fb_cell, 1'b0);
    ct[2] = 1'b1; @(negedge clk); ct[2] = 1'b0; @(negedge clk);
    chk("R5 ct2 clock loads", fb_cell, 1'b1);
    cfg_clk_sel = 3'd3; sop_in = 1'b0;
    gpulse(1);
    chk("R5 unselected gclk1 ignored", fb_cell, 1'b1);
    gpulse(3);
    chk("R5 gclk3 loads", fb_cell, 1'b0);
    cfg_clk_sel = 3'd6; sop_in = 1'b1;
    gpulse(0); gpulse(3);
    chk("R5 select 6 has no clock", fb_cell, 1'b0);
  endtask

  task automatic t_edge();
    cfg_mode = 2'b01; cfg_clk_sel = 3'd2; cfg_gclk_fall = 4'b0100; sop_in = 1'b1;
    gclk[2] = 1'b1; @(negedge clk);
    chk("R6 rising ignored when falling chosen", fb_cell, 1'b0);
    gclk[2] = 1'b0; @(negedge clk);
    chk("R6 falling edge loads", fb_cell, 1'b1);
    cfg_gclk_fall = 4'b0;
  endtask

  task automatic t_async();
    cfg_mode = 2'b01; cfg_clk_sel = 3'd0; cfg_pr_en = 1'b1; sop_in = 1'b0;
    clear_bit(); cfg_pr_en = 1'b1;
    ct[1] = 1'b1; #1;
    chk("R7 preset without clock", fb_cell, 1'b1);
    @(posedge clk); #1 ct[1] = 1'b0;
    @(negedge clk);
    ct[0] = 1'b1; #1;
    chk("R7 clear without clock", fb_cell, 1'b0);
    ct[1] = 1'b1; #1;
    chk("R7 clear wins over preset", fb_cell, 1'b0);
    @(posedge clk); #1 ct = 6'b0;
    @(negedge clk);
    cfg_pr_en = 1'b0;
  endtask

  task automatic t_prdis();
    cfg_mode = 2'b01; cfg_pr_en = 1'b0; sop_in = 1'b1;
    gpulse(0);
    ct[0] = 1'b1; @(negedge clk);
    chk("R8 clear ignored when disabled", fb_cell, 1'b1);
    ct[0] = 1'b0; sop_in = 1'b0; gpulse(0);
    ct[1] = 1'b1; @(negedge clk);
    chk("R8 preset ignored when disabled", fb_cell, 1'b0);
    ct[1] = 1'b0; @(negedge clk);
  endtask

  task automatic t_oe();
    cfg_mode = 2'b00; sop_in = 1'b1;
    cfg_oe_sel = 3'd0; #1;
    chk("R9 never-enable releases pin", pin_io, 1'bz);
    cfg_oe_sel = 3'd1; #1;
    chk("R9 always-enable drives cell value", pin_io, 1'b1);
    cfg_oe_sel = 3'd2; ct[2] = 1'b0; #1;
    chk("R9 ct2 low releases pin", pin_io, 1'bz);
    ct[2] = 1'b1; #1;
    chk("R9 ct2 high drives pin", pin_io, 1'b1);
    ct[2] = 1'b0; cfg_oe_sel = 3'd5; ct[5] = 1'b1; sop_in = 1'b0; #1;
    chk("R9 ct5 high drives 0", pin_io, 1'b0);
    cfg_oe_sel = 3'd7; #1;
    chk("R9 select 7 releases pin", pin_io, 1'bz);
    ct = 6'b0;
    @(negedge clk);
  endtask

  task automatic t_gts();
    cfg_mode = 2'b00; sop_in = 1'b1; cfg_oe_sel = 3'd1;
    cfg_gts_en = 1'b1; gts_n = 1'b0; #1;
    chk("R10 global tri-state releases pin", pin_io, 1'bz);
    chk("R10 cell value kept", fb_cell, 1'b1);
    cfg_gts_en = 1'b0; #1;
    chk("R10 disabled global tri-state ignored", pin_io, 1'b1);
    chk("R11 pin feedback shows driven value", fb_pin, 1'b1);
    gts_n = 1'b1; cfg_oe_sel = 3'd0; ext_en = 1'b1; ext_val = 1'b0; #1;
    chk("R11 pin feedback shows external 0", fb_pin, 1'b0);
    chk("R11 cell feedback independent of pin", fb_cell, 1'b1);
    ext_val = 1'b1; #1;
    chk("R11 pin feedback shows external 1", fb_pin, 1'b1);
    ext_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_dmode();
    t_tmode();
    t_comb();
    t_clksel();
    t_edge();
    t_async();
    t_prdis();
    t_oe();
    t_gts();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule